// File: doc/BRIEF.md
# Thread Waiting Cycle Table

This block keeps a small associative table of the bottlenecks that threads are currently waiting on. Each bottleneck is tagged with an identifier. Cores send a wait-begin event when a thread starts waiting on an identifier and a wait-done event when it stops. Each live entry counts its current waiters. On every clock cycle it adds that count to a saturating waiting-cycle total, so the total measures thread-cycles lost to that bottleneck.

A combinational query port returns, for any identifier, whether it is held, its accumulated total, and whether that total is strictly above a threshold register that software can write. Such bottlenecks are the ones worth running on a faster core. When the table is full, a newly seen identifier replaces the entry with the smallest total. A small notifier state machine reports each change of an entry's above-threshold status as a single-cycle enable or disable event. It has two states. In NOTE_IDLE it emits nothing. In NOTE_SEND it drives the latched event. The transition IDLE->SEND occurs when some entry's status differs from what was last reported. SEND->SEND occurs when another change is still pending. SEND->IDLE occurs when nothing is pending. IDLE->IDLE occurs otherwise.

Top module: `wait_cycle_table`

## Requirements
- R1: After reset every entry is empty: queries miss and return zero cycles with accel low, the threshold equals THR_RESET (all ones by default), and evt_valid_o is low.
- R2: A wait-begin for a held identifier raises its waiter count by one. A wait-done for a held identifier lowers it by one. Both effects are visible in the rate at which the total grows from the next cycle on.
- R3: The waiter count saturates at NUM_CORES and never drops below zero. A wait-done for an identifier that is not held changes nothing and allocates nothing.
- R4: On each clock edge, every valid entry adds the waiter count it held before that edge to its total. With zero waiters the total holds.
- R5: The total is CNT_W bits wide and saturates at all ones instead of wrapping.
- R6: A wait-begin for an identifier that is not held allocates an entry. The lowest-index empty entry is used first. When the table is full, the entry with the smallest total is replaced, and on a tie the lowest index wins. The evicted identifier then misses.
- R7: A wait-begin and a wait-done for the same identifier in one cycle give a net waiter change of zero. That edge still accumulates the previous count. If the identifier was not held, it is allocated with zero waiters.
- R8: A newly allocated entry starts at zero cycles and zero waiters, and the wait-begin is then applied. The query reads 0 cycles after the allocating edge and 1 cycle after the next edge.
- R9: The query is combinational. query_accel_o is 1 only when the entry is held and its total is strictly greater than the threshold, so a total equal to the threshold reads 0.
- R10: When thr_we_i is high at a clock edge, thr_data_i becomes the threshold from that edge on.
- R11: When an entry's above-threshold status changes, one event is produced. evt_valid_o is high for one cycle, with evt_on_o = 1 for enable and 0 for disable, and evt_id_o carries the identifier. The event is driven in the cycle after the first edge that sees the change. When several changes are pending, one event is sent per cycle, lowest entry index first.
- R12: No event is repeated while an entry's status stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_valid_i | input | 1 | A thread starts waiting this cycle |
| begin_id_i | input | ID_W | Identifier of the bottleneck being waited on |
| done_valid_i | input | 1 | A thread stops waiting this cycle |
| done_id_i | input | ID_W | Identifier the thread stopped waiting on |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_data_i | input | CNT_W | New threshold value |
| query_id_i | input | ID_W | Identifier to look up |
| query_hit_o | output | 1 | Identifier is held in the table |
| query_cycles_o | output | CNT_W | Accumulated waiting cycles (0 on miss) |
| query_accel_o | output | 1 | Total is above the threshold |
| evt_valid_o | output | 1 | Status-change event valid |
| evt_on_o | output | 1 | 1 = enable acceleration, 0 = disable |
| evt_id_o | output | ID_W | Identifier the event refers to |

## Verification
The bench builds the table with NUM_ENTRIES = 4, ID_W = 8, CNT_W = 8 and NUM_CORES = 3. With these values the full-table replacement, including its tie case, is reached after a few allocations. The 8-bit total can be driven into saturation in about a hundred cycles. The waiter count reaches its ceiling after three wait-begins. The default all-ones threshold can never be exceeded, so an event appears only after the bench lowers the threshold. This lets the scoreboard predict every event exactly, including two simultaneous enables and two simultaneous disables.

// File: rtl/wct_pkg.sv
package wct_pkg;

    typedef enum logic {
        NOTE_IDLE = 1'b0,
        NOTE_SEND = 1'b1
    } note_state_e;

endpackage

// File: rtl/wct_entry.sv
module wct_entry #(
    parameter int ID_W     = 16,
    parameter int CNT_W    = 24,
    parameter int WAIT_W   = 5,
    parameter int MAX_WAIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ID_W-1:0]   alloc_id_i,
    input  logic              alloc_wait_i,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic [CNT_W-1:0]  thr_i,
    output logic              valid_o,
    output logic [ID_W-1:0]   id_o,
    output logic [CNT_W-1:0]  cycles_o,
    output logic              above_o
);

    localparam int               SUM_W    = CNT_W + 1;
    localparam logic [WAIT_W-1:0] WAIT_TOP = WAIT_W'(MAX_WAIT);
    localparam logic [CNT_W-1:0]  CNT_TOP  = {CNT_W{1'b1}};

    logic              valid_q;
    logic [ID_W-1:0]   id_q;
    logic [CNT_W-1:0]  cycles_q;
    logic [WAIT_W-1:0] waiters_q;

    logic [SUM_W-1:0]  acc_sum;
    logic [CNT_W-1:0]  cycles_d;
    logic [WAIT_W-1:0] waiters_d;

    always_comb begin
        acc_sum  = {1'b0, cycles_q} + SUM_W'(waiters_q);
        cycles_d = acc_sum[CNT_W] ? CNT_TOP : acc_sum[CNT_W-1:0];

        waiters_d = waiters_q;
        if (inc_i && !dec_i && (waiters_q != WAIT_TOP)) begin
            waiters_d = waiters_q + WAIT_W'(1);
        end else if (dec_i && !inc_i && (waiters_q != '0)) begin
            waiters_d = waiters_q - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            id_q      <= '0;
            cycles_q  <= '0;
            waiters_q <= '0;
        end else if (alloc_i) begin
            valid_q   <= 1'b1;
            id_q      <= alloc_id_i;
            cycles_q  <= '0;
            waiters_q <= alloc_wait_i ? WAIT_W'(1) : '0;
        end else if (valid_q) begin
            cycles_q  <= cycles_d;
            waiters_q <= waiters_d;
        end
    end

    assign valid_o  = valid_q;
    assign id_o     = id_q;
    assign cycles_o = cycles_q;
    assign above_o  = valid_q && (cycles_q > thr_i);

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        waiters_q <= WAIT_TOP); // R3

    AST_CYCLES_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !alloc_i) |=> (cycles_q >= $past(cycles_q))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !alloc_i && cycles_q == CNT_TOP) |=> (cycles_q == CNT_TOP)); // R5

    AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> (valid_q && cycles_q == '0)); // R8

endmodule

// File: rtl/wct_victim.sv
module wct_victim #(
    parameter int N     = 32,
    parameter int CNT_W = 24,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][CNT_W-1:0] cycles_i,
    output logic [IDX_W-1:0]        victim_o
);

    logic              free_found;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  min_idx;
    logic [CNT_W-1:0]  min_val;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        min_idx    = '0;
        min_val    = cycles_i[0];
        for (int i = 0; i < N; i++) begin
            if (!valid_i[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (cycles_i[i] < min_val) begin
                min_val = cycles_i[i];
                min_idx = IDX_W'(i);
            end
        end
        victim_o = free_found ? free_idx : min_idx;
    end

endmodule

// File: rtl/wct_notifier.sv
module wct_notifier
    import wct_pkg::*;
#(
    parameter int N     = 32,
    parameter int ID_W  = 16,
    parameter int IDX_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           above_i,
    input  logic [N-1:0]           alloc_i,
    input  logic [N-1:0][ID_W-1:0] ids_i,
    output logic                   evt_valid_o,
    output logic                   evt_on_o,
    output logic [ID_W-1:0]        evt_id_o
);

    note_state_e       state_q, state_d;
    logic [N-1:0]      reported_q;
    logic [N-1:0]      pending;
    logic              pend_any;
    logic [IDX_W-1:0]  pick;
    logic [ID_W-1:0]   evt_id_q;
    logic              evt_on_q;

    always_comb begin
        pending  = (above_i ^ reported_q) & ~alloc_i;
        pend_any = |pending;
        pick     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) pick = IDX_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NOTE_IDLE: state_d = pend_any ? NOTE_SEND : NOTE_IDLE;
            NOTE_SEND: state_d = pend_any ? NOTE_SEND : NOTE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NOTE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_id_q   <= '0;
            evt_on_q   <= 1'b0;
            reported_q <= '0;
        end else begin
            if (pend_any) begin
                evt_id_q <= ids_i[pick];
                evt_on_q <= above_i[pick];
            end
            for (int i = 0; i < N; i++) begin
                if (alloc_i[i]) begin
                    reported_q[i] <= 1'b0;
                end else if (pend_any && (pick == IDX_W'(i))) begin
                    reported_q[i] <= above_i[i];
                end
            end
        end
    end

    always_comb begin
        evt_valid_o = 1'b0;
        unique case (state_q)
            NOTE_IDLE: evt_valid_o = 1'b0;
            NOTE_SEND: evt_valid_o = 1'b1;
        endcase
        evt_id_o = evt_id_q;
        evt_on_o = evt_on_q;
    end

    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_o && $past(evt_valid_o)) |->
        ((evt_id_o != $past(evt_id_o)) || (evt_on_o != $past(evt_on_o)))); // R12

endmodule

// File: rtl/wait_cycle_table.sv
module wait_cycle_table #(
    parameter int               NUM_ENTRIES = 32,
    parameter int               ID_W        = 16,
    parameter int               CNT_W       = 24,
    parameter int               NUM_CORES   = 16,
    parameter logic [CNT_W-1:0] THR_RESET   = {CNT_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_valid_i,
    input  logic [ID_W-1:0]  begin_id_i,
    input  logic             done_valid_i,
    input  logic [ID_W-1:0]  done_id_i,
    input  logic             thr_we_i,
    input  logic [CNT_W-1:0] thr_data_i,
    input  logic [ID_W-1:0]  query_id_i,
    output logic             query_hit_o,
    output logic [CNT_W-1:0] query_cycles_o,
    output logic             query_accel_o,
    output logic             evt_valid_o,
    output logic             evt_on_o,
    output logic [ID_W-1:0]  evt_id_o
);

    localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int WAIT_W = $clog2(NUM_CORES + 1);

    logic [NUM_ENTRIES-1:0]            ent_valid;
    logic [NUM_ENTRIES-1:0]            ent_above;
    logic [NUM_ENTRIES-1:0]            begin_hit;
    logic [NUM_ENTRIES-1:0]            done_hit;
    logic [NUM_ENTRIES-1:0]            alloc_vec;
    logic [NUM_ENTRIES-1:0][ID_W-1:0]  ent_id;
    logic [NUM_ENTRIES-1:0][CNT_W-1:0] ent_cycles;
    logic [IDX_W-1:0]                  victim_idx;
    logic [CNT_W-1:0]                  thr_q;
    logic                              begin_miss;
    logic                              alloc_wait;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        thr_q <= THR_RESET;
        else if (thr_we_i) thr_q <= thr_data_i;
    end

    assign begin_miss = begin_valid_i && !(|begin_hit);
    assign alloc_wait = !(done_valid_i && (done_id_i == begin_id_i));

    always_comb begin
        alloc_vec = '0;
        if (begin_miss) alloc_vec[victim_idx] = 1'b1;
    end

    wct_victim #(
        .N     (NUM_ENTRIES),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_victim (
        .valid_i  (ent_valid),
        .cycles_i (ent_cycles),
        .victim_o (victim_idx)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        assign begin_hit[g] = ent_valid[g] && (ent_id[g] == begin_id_i);
        assign done_hit[g]  = ent_valid[g] && (ent_id[g] == done_id_i);

        wct_entry #(
            .ID_W     (ID_W),
            .CNT_W    (CNT_W),
            .WAIT_W   (WAIT_W),
            .MAX_WAIT (NUM_CORES)
        ) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (alloc_vec[g]),
            .alloc_id_i   (begin_id_i),
            .alloc_wait_i (alloc_wait),
            .inc_i        (begin_valid_i && begin_hit[g]),
            .dec_i        (done_valid_i && done_hit[g]),
            .thr_i        (thr_q),
            .valid_o      (ent_valid[g]),
            .id_o         (ent_id[g]),
            .cycles_o     (ent_cycles[g]),
            .above_o      (ent_above[g])
        );
    end

    always_comb begin
        query_hit_o    = 1'b0;
        query_cycles_o = '0;
        query_accel_o  = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (ent_valid[i] && (ent_id[i] == query_id_i)) begin
                query_hit_o    = 1'b1;
                query_cycles_o = query_cycles_o | ent_cycles[i];
                query_accel_o  = query_accel_o | ent_above[i];
            end
        end
    end

    wct_notifier #(
        .N     (NUM_ENTRIES),
        .ID_W  (ID_W),
        .IDX_W (IDX_W)
    ) u_notifier (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_i     (ent_above),
        .alloc_i     (alloc_vec),
        .ids_i       (ent_id),
        .evt_valid_o (evt_valid_o),
        .evt_on_o    (evt_on_o),
        .evt_id_o    (evt_id_o)
    );

    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec)); // R6

    AST_UNIQUE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(begin_hit)); // R6

    AST_DONE_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!begin_valid_i && done_valid_i && !(|done_hit)) |=> (ent_valid == $past(ent_valid))); // R3

endmodule

// File: tb/wait_cycle_table_tb.sv
`timescale 1ns/1ps
module wait_cycle_table_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       begin_valid_i = 1'b0;
    logic [7:0] begin_id_i = '0;
    logic       done_valid_i = 1'b0;
    logic [7:0] done_id_i = '0;
    logic       thr_we_i = 1'b0;
    logic [7:0] thr_data_i = '0;
    logic [7:0] query_id_i = '0;
    logic       query_hit_o;
    logic [7:0] query_cycles_o;
    logic       query_accel_o;
    logic       evt_valid_o;
    logic       evt_on_o;
    logic [7:0] evt_id_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_id_q[$];
    bit         exp_on_q[$];

    always #4 clk = ~clk;

    wait_cycle_table #(
        .NUM_ENTRIES (4),
        .ID_W        (8),
        .CNT_W       (8),
        .NUM_CORES   (3)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .begin_valid_i  (begin_valid_i),
        .begin_id_i     (begin_id_i),
        .done_valid_i   (done_valid_i),
        .done_id_i      (done_id_i),
        .thr_we_i       (thr_we_i),
        .thr_data_i     (thr_data_i),
        .query_id_i     (query_id_i),
        .query_hit_o    (query_hit_o),
        .query_cycles_o (query_cycles_o),
        .query_accel_o  (query_accel_o),
        .evt_valid_o    (evt_valid_o),
        .evt_on_o       (evt_on_o),
        .evt_id_o       (evt_id_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic qchk(input string tag, input logic [7:0] id, input int hit,
                        input int cyc, input int acc);
        query_id_i = id;
        #1;
        chk({tag, " hit"}, int'(query_hit_o), hit);
        chk({tag, " cycles"}, int'(query_cycles_o), cyc);
        chk({tag, " accel"}, int'(query_accel_o), acc);
    endtask

    task automatic cyc(input logic bv, input logic [7:0] bid, input logic dv,
                       input logic [7:0] did);
        begin_valid_i = bv; begin_id_i = bid;
        done_valid_i  = dv; done_id_i  = did;
        @(posedge clk);
        @(negedge clk);
        begin_valid_i = 1'b0;
        done_valid_i  = 1'b0;
    endtask

    task automatic wr_thr(input logic [7:0] v);
        thr_we_i = 1'b1; thr_data_i = v;
        @(posedge clk);
        @(negedge clk);
        thr_we_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_evt(input logic [7:0] id, input bit on);
        exp_id_q.push_back(id);
        exp_on_q.push_back(on);
    endtask

    // scoreboard monitor for status-change events (R11, R12)
    always @(negedge clk) begin
        if (rst_n && evt_valid_o) begin
            if (exp_id_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R12 unexpected event actual=id%0d/on%0d expected=none",
                         evt_id_o, evt_on_o);
            end else begin
                chk("R11 event id", int'(evt_id_o), int'(exp_id_q.pop_front()));
                chk("R11 event direction", int'(evt_on_o), int'(exp_on_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        qchk("R1 empty", 8'd5, 0, 0, 0);
        chk("R1 no event", int'(evt_valid_o), 0);

        // R8 / R6 allocation into free entry
        cyc(1, 8'd10, 0, 8'd0);
        qchk("R8 fresh", 8'd10, 1, 0, 0);
        idle(1);
        qchk("R4 one waiter", 8'd10, 1, 1, 0);

        // R2 increment and decrement
        cyc(1, 8'd10, 0, 8'd0);
        idle(3);
        qchk("R2 two waiters", 8'd10, 1, 8, 0);
        cyc(0, 8'd0, 1, 8'd10);
        idle(2);
        qchk("R2 after done", 8'd10, 1, 12, 0);

        // R7 begin and done on same id
        cyc(1, 8'd10, 1, 8'd10);
        idle(1);
        qchk("R7 net zero", 8'd10, 1, 14, 0);

        // R3 done for unknown id ignored
        cyc(0, 8'd0, 1, 8'd77);
        qchk("R3 unknown miss", 8'd77, 0, 0, 0);
        qchk("R3 others unaffected", 8'd10, 1, 15, 0);

        // R3 floor at zero, R4 hold with zero waiters
        cyc(0, 8'd0, 1, 8'd10);
        cyc(0, 8'd0, 1, 8'd10);
        idle(3);
        qchk("R4 zero waiters hold", 8'd10, 1, 16, 0);
        cyc(1, 8'd10, 0, 8'd0);
        idle(1);
        qchk("R3 no underflow", 8'd10, 1, 17, 0);
        cyc(0, 8'd0, 1, 8'd10);
        qchk("R2 back to zero", 8'd10, 1, 18, 0);

        // R3 waiter saturation at 3
        for (int k = 0; k < 5; k++) cyc(1, 8'd20, 0, 8'd0);
        idle(2);
        qchk("R3 waiter ceiling", 8'd20, 1, 15, 0);
        for (int k = 0; k < 3; k++) cyc(0, 8'd0, 1, 8'd20);
        qchk("R3 drained", 8'd20, 1, 21, 0);

        // R6 fill and replace: tie case
        cyc(1, 8'd30, 0, 8'd0);
        cyc(0, 8'd0, 1, 8'd30);
        cyc(1, 8'd40, 0, 8'd0);
        cyc(0, 8'd0, 1, 8'd40);
        cyc(1, 8'd50, 0, 8'd0);
        qchk("R6 tie evicted", 8'd30, 0, 0, 0);
        qchk("R6 new entry", 8'd50, 1, 0, 0);
        qchk("R6 survivor", 8'd40, 1, 1, 0);
        idle(2);
        cyc(0, 8'd0, 1, 8'd50);
        qchk("R6 grown", 8'd50, 1, 3, 0);

        // R6 minimum-total victim not lowest index
        cyc(1, 8'd60, 0, 8'd0);
        qchk("R6 min evicted", 8'd40, 0, 0, 0);
        qchk("R6 kept larger", 8'd50, 1, 3, 0);
        qchk("R6 placed", 8'd60, 1, 0, 0);

        // R5 total saturation, R9 equal to threshold not above
        cyc(1, 8'd60, 0, 8'd0);
        cyc(1, 8'd60, 0, 8'd0);
        idle(90);
        qchk("R5 R9 saturated", 8'd60, 1, 255, 0);
        idle(2);
        qchk("R5 stays saturated", 8'd60, 1, 255, 0);
        for (int k = 0; k < 3; k++) cyc(0, 8'd0, 1, 8'd60);

        // R10 threshold write, R11 two simultaneous enables in index order
        expect_evt(8'd20, 1'b1);
        expect_evt(8'd60, 1'b1);
        wr_thr(8'd20);
        qchk("R10 above new threshold", 8'd20, 1, 21, 1);
        qchk("R9 below threshold", 8'd10, 1, 18, 0);
        idle(4);
        chk("R11 enables drained", exp_id_q.size(), 0);

        // R11 crossing by accumulation
        expect_evt(8'd10, 1'b1);
        cyc(1, 8'd10, 0, 8'd0);
        idle(4);
        cyc(0, 8'd0, 1, 8'd10);
        qchk("R9 crossed", 8'd10, 1, 23, 1);

        // R11 disables after raising the threshold
        expect_evt(8'd10, 1'b0);
        expect_evt(8'd20, 1'b0);
        wr_thr(8'd200);
        qchk("R10 raised threshold", 8'd10, 1, 23, 0);
        qchk("R10 still above", 8'd60, 1, 255, 1);
        idle(4);

        // R12 quiet while status is unchanged
        idle(10);
        chk("R12 all expected events seen", exp_id_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule